// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects level-sensitive interrupt lines from on-chip peripherals and presents one combined request to a host processor. Software sees four 32-bit registers through a small read/write port: a control word, an enable mask, an in-service set and a vector word. Each source has a rank. The rank comes from its index, except that one configurable source can be promoted to the top and the four highest-numbered sources form a group whose internal order software can permute.

The handler acknowledges by writing 1 to bit 0 of the vector word. The controller then latches the number of the best eligible source and marks that source in service. Software reads the vector word to get that number. A source stays in service until software writes a 1 to its bit in the in-service register. While it is in service, sources of equal or lower rank are held off. If the request disappears before the acknowledge, for example because software masked the source in that window, the acknowledge returns the reserved vector 0 and nothing is marked in service. For this reason input 0 is never treated as a real source.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `host_irq` is low, the mask, in-service and vector registers read 0, and the control word reads 0x0000_00E4. That value means enable off, level 0, no promoted source and identity group order.
- R2: A source is pending only while its input is high and its bit in the mask register (address 1) is 1. With a mask bit of 0 the source cannot raise `host_irq`.
- R3: `host_irq` stays low until control bit 16 (global enable) is 1. `host_lvl` always equals control bits 15:13.
- R4: Among eligible ordinary sources, the one with the higher index is chosen.
- R5: Control bits 12:8 name a promoted source that outranks every other source. The value 0 promotes nothing.
- R6: Inputs NSRC-4..NSRC-1 form a group. Group slot k occupies rank NSRC-4+k, so slot 3 is the highest. Control bits 2k+1:2k name the group input placed in slot k. A group input named by no slot is never chosen.
- R7: Writing address 3 with bit 0 set is an acknowledge. It works with or without the global enable. It latches the chosen source number and sets that source's in-service bit. Reading address 3 then returns the number in bits 15:11, with every other bit 0.
- R8: While any source is in service, sources of equal or lower rank do not request. A source of higher rank still does.
- R9: Writing address 2 clears each in-service bit written with 1. Bits written with 0 keep their value.
- R10: An acknowledge with no eligible source returns vector 0 and sets no in-service bit. Input 0 is never chosen.
- R11: Sources are level-sensitive: a request is withdrawn as soon as its input falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NSRC | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 control, 1 mask, 2 in-service, 3 vector |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| host_irq | output | 1 | Combined request to the host |
| host_lvl | output | 3 | Host interrupt level the request is presented on |

## Verification
The bound checker covers the rules that hold every cycle. The request is gated by the enable and the mask. The level output changes only when the control word is written. In-service bits are set only by an acknowledge that found a source, and one acknowledge sets exactly one bit. An end-of-interrupt write leaves the zero-written bits alone. Input 0 never enters service. Which source wins cannot be expressed as a simple property, so the directed scenarios show it: index order, promotion, group permutation, hold-off behind a source in service, and the returned vector value, including vector 0 after a mask race.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC = 32,
  parameter int GRP  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  output logic            host_irq,
  output logic [2:0]      host_lvl
);
  localparam int IDW   = $clog2(NSRC);
  localparam int RW    = IDW + 1;
  localparam int SW    = $clog2(GRP);
  localparam int GBASE = NSRC - GRP;
  localparam int HP_LO = SW * GRP;
  localparam int LV_LO = 13;
  localparam int EN_B  = 16;
  localparam int VC_LO = 11;

  logic [SW-1:0]   slot_q [GRP];
  logic [IDW-1:0]  hp_q;
  logic [2:0]      lvl_q;
  logic            en_q;
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] isr_q;
  logic [IDW-1:0]  vec_q;

  logic [RW-1:0]   rank [NSRC];
  logic [NSRC-1:0] valid;
  logic [NSRC-1:0] elig;
  logic [RW-1:0]   isr_top;
  logic [RW-1:0]   best_r;
  logic [IDW-1:0]  win_id;
  logic            any_elig;
  logic [HP_LO-1:0] slot_flat;
  logic            ack;

  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      valid[s] = (s != 0);
      rank[s]  = RW'(s);
      if (s >= GBASE) begin
        valid[s] = 1'b0;
        rank[s]  = '0;
        for (int k = 0; k < GRP; k++)
          if (slot_q[k] == SW'(s - GBASE)) begin
            valid[s] = 1'b1;
            rank[s]  = RW'(GBASE + k);
          end
      end
    end
    if (hp_q != '0) begin
      valid[hp_q] = 1'b1;
      rank[hp_q]  = RW'(NSRC);
    end
  end

  always_comb begin
    isr_top = '0;
    for (int s = 0; s < NSRC; s++)
      if (isr_q[s] && valid[s] && rank[s] > isr_top) isr_top = rank[s];
  end

  always_comb begin
    best_r = '0;
    win_id = '0;
    for (int s = 0; s < NSRC; s++) begin
      elig[s] = src[s] && mask_q[s] && valid[s] && (rank[s] > isr_top);
      if (elig[s] && rank[s] > best_r) begin
        best_r = rank[s];
        win_id = IDW'(s);
      end
    end
  end

  assign any_elig = |elig;
  assign host_irq = en_q & any_elig;
  assign host_lvl = lvl_q;
  assign ack      = wr_en && addr == 2'd3 && wdata[0];

  always_comb
    for (int k = 0; k < GRP; k++) slot_flat[k*SW +: SW] = slot_q[k];

  always_comb
    case (addr)
      2'd0:    rdata = 32'({en_q, lvl_q, {(LV_LO-HP_LO-IDW){1'b0}}, hp_q, slot_flat});
      2'd1:    rdata = 32'(mask_q);
      2'd2:    rdata = 32'(isr_q);
      default: rdata = 32'({vec_q, {VC_LO{1'b0}}});
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < GRP; k++) slot_q[k] <= SW'(k);
      hp_q   <= '0;
      lvl_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          for (int k = 0; k < GRP; k++) slot_q[k] <= wdata[k*SW +: SW];
          hp_q  <= wdata[HP_LO +: IDW];
          lvl_q <= wdata[LV_LO +: 3];
          en_q  <= wdata[EN_B];
        end
        2'd1: mask_q <= wdata[NSRC-1:0];
        2'd2: isr_q  <= isr_q & ~wdata[NSRC-1:0];
        default:
          if (ack) begin
            vec_q <= any_elig ? win_id : '0;
            if (any_elig) isr_q[win_id] <= 1'b1;
          end
      endcase
    end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src,
  input logic            wr_en,
  input logic [1:0]      addr,
  input logic [31:0]     wdata,
  input logic            host_irq,
  input logic [2:0]      host_lvl,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] isr_q,
  input logic            en_q
);
  logic ack_c, eoi_c, cfg_c;
  assign ack_c = wr_en && addr == 2'd3 && wdata[0];
  assign eoi_c = wr_en && addr == 2'd2;
  assign cfg_c = wr_en && addr == 2'd0;

  p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((src & mask_q) == '0) |-> !host_irq);
  p_enable_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !host_irq);
  p_lvl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_c |=> $stable(host_lvl));
  p_ack_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_c && host_irq) |=> $countones(isr_q) == $countones($past(isr_q)) + 1);
  p_set_by_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_c |=> (isr_q & ~$past(isr_q)) == '0);
  p_eoi_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_c |=> (isr_q & ~$past(wdata[NSRC-1:0])) == ($past(isr_q) & ~$past(wdata[NSRC-1:0])));
  p_err_no_isr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_c && en_q && !host_irq) |=> isr_q == $past(isr_q));
  p_src0_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !isr_q[0]);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .host_irq(host_irq), .host_lvl(host_lvl),
  .mask_q(mask_q), .isr_q(isr_q), .en_q(en_q)
);

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int NSRC = 32;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [NSRC-1:0] src = '0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic host_irq;
  logic [2:0] host_lvl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC)) i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .host_irq(host_irq), .host_lvl(host_lvl));

  localparam logic [31:0] CFG_BASE = 32'h0001_A0E4;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic irq_is(string req, logic exp);
    @(negedge clk); #1 chk(req, 32'(host_irq), 32'(exp));
  endtask

  task automatic ack_expect(string req, int id);
    logic [31:0] v;
    wr(2'd3, 32'h1);
    rd(2'd3, v);
    chk(req, v, 32'(id) << 11);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1 chk("R1 irq", 32'(host_irq), 0);
    rd(2'd0, v); chk("R1 cfg", v, 32'h0000_00E4);
    rd(2'd1, v); chk("R1 mask", v, 0);
    rd(2'd2, v); chk("R1 isr", v, 0);
    rd(2'd3, v); chk("R1 vec", v, 0);
  endtask

  task automatic t_gate;
    src = 32'h20;
    irq_is("R2 no mask", 0);
    wr(2'd1, 32'h20);
    irq_is("R3 enable off", 0);
    wr(2'd0, CFG_BASE);
    irq_is("R3 enable on", 1);
    chk("R3 level", 32'(host_lvl), 5);
    wr(2'd1, 32'h0);
    irq_is("R2 masked", 0);
    src = '0;
  endtask

  task automatic t_priority;
    logic [31:0] v;
    wr(2'd1, 32'hFFFF_FFFF);
    src = (32'h1 << 3) | (32'h1 << 9);
    ack_expect("R4 R7 higher index", 9);
    rd(2'd2, v); chk("R7 isr set", v, 32'h1 << 9);
    irq_is("R8 held off", 0);
    src[12] = 1;
    irq_is("R8 higher preempts", 1);
    ack_expect("R8 nested vector", 12);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R9 zero write keeps", v, (32'h1 << 9) | (32'h1 << 12));
    wr(2'd2, 32'h1 << 12);
    rd(2'd2, v); chk("R9 clear one", v, 32'h1 << 9);
    wr(2'd2, 32'h1 << 9);
    rd(2'd2, v); chk("R9 clear all", v, 0);
    src = '0;
  endtask

  task automatic t_promote;
    src = (32'h1 << 3) | (32'h1 << 12);
    wr(2'd0, CFG_BASE | (32'd3 << 8));
    ack_expect("R5 promoted", 3);
    src[12] = 0;
    irq_is("R5 promoted blocks all", 0);
    wr(2'd2, 32'h8);
    wr(2'd0, CFG_BASE);
    src = '0;
  endtask

  task automatic t_group;
    src = (32'h1 << 28) | (32'h1 << 31);
    wr(2'd0, 32'h0001_A036);
    ack_expect("R6 permuted slot3", 28);
    wr(2'd2, 32'h1 << 28);
    src = 32'h1 << 30;
    wr(2'd0, 32'h0001_A055);
    irq_is("R6 unnamed input", 0);
    wr(2'd0, CFG_BASE);
    irq_is("R6 identity restored", 1);
    src = '0;
  endtask

  task automatic t_error;
    logic [31:0] v;
    src = 32'h1 << 20;
    irq_is("R11 raised", 1);
    wr(2'd1, ~(32'h1 << 20));
    ack_expect("R10 race vector", 0);
    rd(2'd2, v); chk("R10 no isr", v, 0);
    wr(2'd1, 32'hFFFF_FFFF);
    irq_is("R11 still high", 1);
    src = '0;
    irq_is("R11 withdrawn", 0);
    src = 32'h1;
    irq_is("R10 input0 ignored", 0);
    ack_expect("R10 input0 vector", 0);
    src = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_gate;
    t_priority;
    t_promote;
    t_group;
    t_error;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule